// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This controller turns a single multi-register load or store request into a series of single-word memory transfers. A request carries a register mask, a base address, an addressing mode, a direction bit and a writeback flag. Once the request is accepted, the block presents one register index and one word address per beat on a valid/ready handshake. It advances only when the memory side accepts the beat.

The register file and the memory stay outside the block. The sequencer only produces indices and addresses. After the last beat it gives a one-cycle completion pulse and the updated base value. Surrounding logic writes that value back to the base register when writeback was requested.

The sequencer supports four direct addressing modes. It also supports four stack-style aliases, whose meaning depends on whether the request is a load or a store. Registers always go out lowest index first, and the lowest index always gets the lowest address.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, startReady is 1, xferValid is 0, done is 0 and wbValid is 0.
- R2: An accepted request with a non-zero mask produces exactly one beat per set mask bit. xferReg carries the bit positions in strictly ascending order. The first beat is presented in the cycle after acceptance.
- R3: With modeSel[2]=0, modeSel[1:0] selects the mode: 00 is ascending-from-base, 01 is ascending-from-base+4, 10 is descending-ending-at-base and 11 is descending-ending-below-base. For n set bits, the first beat's address is base, base+4, base-4n+4 and base-4n respectively.
- R4: Each later beat's address is 4 higher than the previous beat's address, in every mode.
- R5: With modeSel[2]=1 and isLoad=0, the alias modeSel[1:0] maps as follows: 00 (full-down) acts as 11, 01 (full-up) acts as 01, 10 (empty-down) acts as 10, and 11 (empty-up) acts as 00.
- R6: With modeSel[2]=1 and isLoad=1, the alias modeSel[1:0] maps as follows: 00 acts as 00, 01 acts as 10, 10 acts as 01, and 11 acts as 11.
- R7: In the cycle after the last beat is accepted, done is 1 for exactly one cycle. In that cycle wbValue is base+4n for modes 00 and 01, or base-4n for modes 10 and 11, taken modulo 2^32. wbValid equals the captured wbEn.
- R8: A request with an all-zero mask produces no beat. done rises in the cycle after acceptance, and wbValue equals the base.
- R9: While xferValid is 1 and xferReady is 0, xferReg and xferAddr hold their values into the next cycle.
- R10: startReady is 0 from acceptance until the cycle after done. A startValid seen in that span is ignored and does not alter the current request.
- R11: xferLoad equals the isLoad value captured with the request, on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request present |
| startReady | output | 1 | Sequencer idle, request taken this cycle if valid |
| regMask | input | 16 | Register selection mask |
| baseAddr | input | 32 | Base address of the request |
| modeSel | input | 3 | Bit 2 selects alias decoding, bits 1:0 the mode or alias |
| isLoad | input | 1 | 1 for load, 0 for store |
| wbEn | input | 1 | Request base writeback |
| xferValid | output | 1 | A beat is presented |
| xferReady | input | 1 | Memory accepts the presented beat |
| xferReg | output | 4 | Register index of the beat |
| xferAddr | output | 32 | Word address of the beat |
| xferLoad | output | 1 | Direction of the beat |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Writeback of wbValue required |
| wbValue | output | 32 | Updated base value |

## Verification
Two events can land in the same cycle: a stalled beat held for the memory, and a fresh request offered while the sequencer is busy. The bench keeps startValid high for whole runs, with an inverted mask and an inverted base. It also drops xferReady on selected beats, so the stall and the ignored request coincide.

Each run is judged against arithmetic expectations from the original request: per-beat register index, address and step, held values during the stall, and the final base. The sweep covers every mode and alias, both directions, both writeback settings, and a base of zero that wraps.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    AM_UP_AT   = 2'b00,
    AM_UP_NEXT = 2'b01,
    AM_DN_AT   = 2'b10,
    AM_DN_NEXT = 2'b11
  } addrMode_e;

  typedef struct packed {
    logic capture;
    logic advance;
  } seqStrobe_t;

  // Decode direct mode or stack alias into an effective addressing mode.
  function automatic addrMode_e resolveMode(input logic [2:0] sel, input logic load);
    addrMode_e m;
    if (!sel[2]) begin
      m = addrMode_e'(sel[1:0]);
    end else if (!load) begin
      case (sel[1:0])
        2'b00:   m = AM_DN_NEXT;
        2'b01:   m = AM_UP_NEXT;
        2'b10:   m = AM_DN_AT;
        default: m = AM_UP_AT;
      endcase
    end else begin
      case (sel[1:0])
        2'b00:   m = AM_UP_AT;
        2'b01:   m = AM_DN_AT;
        2'b10:   m = AM_UP_NEXT;
        default: m = AM_DN_NEXT;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       reqEmpty,
  input  logic       lastBeat,
  input  logic       xferReady,
  output seqStrobe_t strobe,
  output logic       startReady,
  output logic       xferValid,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} seqState_e;
  seqState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (startValid) state <= reqEmpty ? S_DONE : S_RUN;
        S_RUN:   if (xferReady && lastBeat) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    startReady     = (state == S_IDLE);
    xferValid      = (state == S_RUN);
    done           = (state == S_DONE);
    strobe.capture = startReady && startValid;
    strobe.advance = xferValid && xferReady;
  end

endmodule

// File: rtl/blkxfer_path.sv
module blkxfer_path
  import blkxfer_pkg::*;
#(
  parameter int REG_COUNT  = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(REG_COUNT),
  localparam int CNT_W     = $clog2(REG_COUNT + 1),
  localparam int SHIFT     = $clog2(WORD_BYTES)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [REG_COUNT-1:0] regMask,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [2:0]           modeSel,
  input  logic                 isLoad,
  input  logic                 wbEn,
  output logic                 reqEmpty,
  output logic                 lastBeat,
  output logic [IDX_W-1:0]     xferReg,
  output logic [ADDR_W-1:0]    xferAddr,
  output logic                 xferLoad,
  output logic                 wbEnHeld,
  output logic [ADDR_W-1:0]    wbValue
);

  logic [REG_COUNT-1:0] pendMask;
  logic [ADDR_W-1:0]    curAddr;
  logic [ADDR_W-1:0]    endBase;
  logic                 heldLoad;
  logic                 heldWb;

  logic [CNT_W-1:0]     reqCount;
  logic [ADDR_W-1:0]    spanBytes;
  logic [ADDR_W-1:0]    wordStep;
  logic [ADDR_W-1:0]    firstAddr;
  logic [ADDR_W-1:0]    finalBase;
  logic [IDX_W-1:0]     lowIdx;
  addrMode_e            effMode;

  // Number of registers in the incoming request.
  always_comb begin
    reqCount = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      reqCount = reqCount + CNT_W'(regMask[i]);
    end
  end

  assign wordStep  = ADDR_W'(WORD_BYTES);
  assign spanBytes = ADDR_W'(reqCount) << SHIFT;
  assign effMode   = resolveMode(modeSel, isLoad);

  // Lowest register always lands on the lowest address.
  always_comb begin
    case (effMode)
      AM_UP_AT:   firstAddr = baseAddr;
      AM_UP_NEXT: firstAddr = baseAddr + wordStep;
      AM_DN_AT:   firstAddr = baseAddr - spanBytes + wordStep;
      default:    firstAddr = baseAddr - spanBytes;
    endcase
    finalBase = effMode[1] ? (baseAddr - spanBytes) : (baseAddr + spanBytes);
  end

  // Lowest pending register index.
  always_comb begin
    lowIdx = '0;
    for (int i = REG_COUNT - 1; i >= 0; i--) begin
      if (pendMask[i]) lowIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      curAddr  <= '0;
      endBase  <= '0;
      heldLoad <= 1'b0;
      heldWb   <= 1'b0;
    end else if (strobe.capture) begin
      pendMask <= regMask;
      curAddr  <= firstAddr;
      endBase  <= finalBase;
      heldLoad <= isLoad;
      heldWb   <= wbEn;
    end else if (strobe.advance) begin
      pendMask <= pendMask & (pendMask - 1'b1);
      curAddr  <= curAddr + wordStep;
    end
  end

  assign reqEmpty = (regMask == '0);
  assign lastBeat = ((pendMask & (pendMask - 1'b1)) == '0);
  assign xferReg  = lowIdx;
  assign xferAddr = curAddr;
  assign xferLoad = heldLoad;
  assign wbEnHeld = heldWb;
  assign wbValue  = endBase;

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int REG_COUNT  = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(REG_COUNT)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  output logic                 startReady,
  input  logic [REG_COUNT-1:0] regMask,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [2:0]           modeSel,
  input  logic                 isLoad,
  input  logic                 wbEn,
  output logic                 xferValid,
  input  logic                 xferReady,
  output logic [IDX_W-1:0]     xferReg,
  output logic [ADDR_W-1:0]    xferAddr,
  output logic                 xferLoad,
  output logic                 done,
  output logic                 wbValid,
  output logic [ADDR_W-1:0]    wbValue
);

  seqStrobe_t strobe;
  logic       reqEmpty;
  logic       lastBeat;
  logic       wbEnHeld;

  blkxfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .reqEmpty   (reqEmpty),
    .lastBeat   (lastBeat),
    .xferReady  (xferReady),
    .strobe     (strobe),
    .startReady (startReady),
    .xferValid  (xferValid),
    .done       (done)
  );

  blkxfer_path #(
    .REG_COUNT  (REG_COUNT),
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regMask  (regMask),
    .baseAddr (baseAddr),
    .modeSel  (modeSel),
    .isLoad   (isLoad),
    .wbEn     (wbEn),
    .reqEmpty (reqEmpty),
    .lastBeat (lastBeat),
    .xferReg  (xferReg),
    .xferAddr (xferAddr),
    .xferLoad (xferLoad),
    .wbEnHeld (wbEnHeld),
    .wbValue  (wbValue)
  );

  assign wbValid = done && wbEnHeld;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              startReady,
  input logic              xferValid,
  input logic              xferReady,
  input logic [IDX_W-1:0]  xferReg,
  input logic [ADDR_W-1:0] xferAddr,
  input logic              done,
  input logic              wbValid
);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferReady) |=> (xferValid && $stable(xferReg) && $stable(xferAddr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferReady) |=> (!xferValid || (xferAddr == $past(xferAddr) + ADDR_W'(WORD_BYTES))));

  assert_reg_ascend_R2: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferReady) |=> (!xferValid || (xferReg > $past(xferReg))));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startReady, xferValid, done}));

  assert_wb_in_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

endmodule

bind blkxfer_seq blkxfer_seq_chk #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReady (startReady),
  .xferValid  (xferValid),
  .xferReady  (xferReady),
  .xferReg    (xferReg),
  .xferAddr   (xferAddr),
  .done       (done),
  .wbValid    (wbValid)
);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [15:0] regMask = '0;
  logic [31:0] baseAddr = '0;
  logic [2:0]  modeSel = '0;
  logic        isLoad = 1'b0;
  logic        wbEn = 1'b0;
  logic        xferValid;
  logic        xferReady = 1'b1;
  logic [3:0]  xferReg;
  logic [31:0] xferAddr;
  logic        xferLoad;
  logic        done;
  logic        wbValid;
  logic [31:0] wbValue;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  blkxfer_seq u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .regMask(regMask), .baseAddr(baseAddr), .modeSel(modeSel), .isLoad(isLoad),
    .wbEn(wbEn), .xferValid(xferValid), .xferReady(xferReady), .xferReg(xferReg),
    .xferAddr(xferAddr), .xferLoad(xferLoad), .done(done), .wbValid(wbValid),
    .wbValue(wbValue)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expMode(input logic [2:0] sel, input logic ld);
    if (!sel[2]) return sel[1:0];
    if (!ld) begin
      case (sel[1:0])
        2'd0: return 2'd3;
        2'd1: return 2'd1;
        2'd2: return 2'd2;
        default: return 2'd0;
      endcase
    end
    case (sel[1:0])
      2'd0: return 2'd0;
      2'd1: return 2'd2;
      2'd2: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [15:0] pickMask(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001;
      3: return 16'h8000;
      default: return 16'((k * 40503) ^ (k << 7));
    endcase
  endfunction

  task automatic runReq(input logic [15:0] m, input logic [31:0] b, input logic [2:0] sel,
                        input logic ld, input logic wb, input int seed, input bit junk);
    logic [1:0]  em;
    int          n;
    int          k;
    logic [31:0] first;
    logic [31:0] fin;
    logic [31:0] prev;
    string       tag;
    @(negedge clk);
    chk(startReady == 1'b1, "R10", 32'(startReady), 32'd1);
    startValid = 1'b1; regMask = m; baseAddr = b; modeSel = sel; isLoad = ld; wbEn = wb;
    xferReady = 1'b1;
    @(negedge clk);
    if (junk) begin
      regMask = ~m; baseAddr = ~b; modeSel = ~sel; isLoad = ~ld; wbEn = ~wb;
    end else begin
      startValid = 1'b0;
    end
    em = expMode(sel, ld);
    n = $countones(m);
    case (em)
      2'd0: first = b;
      2'd1: first = b + 32'd4;
      2'd2: first = b - 32'(4 * n) + 32'd4;
      default: first = b - 32'(4 * n);
    endcase
    fin = em[1] ? b - 32'(4 * n) : b + 32'(4 * n);
    tag = sel[2] ? (ld ? "R6" : "R5") : "R3";
    if (m == 16'h0) begin
      chk(xferValid == 1'b0, "R8", 32'(xferValid), 32'd0);
      chk(done == 1'b1, "R8", 32'(done), 32'd1);
      chk(wbValue == b, "R8", wbValue, b);
    end else begin
      k = 0;
      prev = '0;
      for (int r = 0; r < 16; r++) begin
        if (m[r]) begin
          chk(xferValid == 1'b1, "R2", 32'(xferValid), 32'd1);
          chk(xferReg == 4'(r), "R2", 32'(xferReg), 32'(r));
          chk(xferAddr == first + 32'(4 * k), tag, xferAddr, first + 32'(4 * k));
          if (k > 0) chk(xferAddr == prev + 32'd4, "R4", xferAddr, prev + 32'd4);
          chk(xferLoad == ld, "R11", 32'(xferLoad), 32'(ld));
          if (junk) chk(startReady == 1'b0, "R10", 32'(startReady), 32'd0);
          prev = xferAddr;
          if (((r + seed) % 3) == 0) begin
            xferReady = 1'b0;
            @(negedge clk);
            chk(xferValid == 1'b1 && xferReg == 4'(r), "R9", 32'(xferReg), 32'(r));
            chk(xferAddr == prev, "R9", xferAddr, prev);
            xferReady = 1'b1;
          end
          @(negedge clk);
          k++;
        end
      end
      chk(xferValid == 1'b0, "R2", 32'(xferValid), 32'd0);
      chk(done == 1'b1, "R7", 32'(done), 32'd1);
      chk(wbValue == fin, "R7", wbValue, fin);
    end
    chk(wbValid == wb, "R7", 32'(wbValid), 32'(wb));
    startValid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(startReady == 1'b1, "R1", 32'(startReady), 32'd1);
    chk(xferValid == 1'b0, "R1", 32'(xferValid), 32'd0);
    chk(done == 1'b0 && wbValid == 1'b0, "R1", 32'(done), 32'd0);
    rstN = 1'b1;
    for (int sel = 0; sel < 8; sel++) begin
      for (int ld = 0; ld < 2; ld++) begin
        for (int wb = 0; wb < 2; wb++) begin
          for (int mk = 0; mk < 12; mk++) begin
            runReq(pickMask(mk), (mk == 4) ? 32'h0 : 32'h2000 + 32'(mk * 256),
                   3'(sel), 1'(ld), 1'(wb), mk + sel, ((mk + sel + ld) % 2) == 1);
          end
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule